// File: doc/BRIEF.md
# Memory Map Decoder with Port Latches

This block sits between the address bus of a small 8-bit processor board and its memories and I/O. It looks at a 16-bit address together with a read/write flag and a bus-valid strobe. From these it decides whether the cycle targets the 1 KB on-board RAM, one of two fixed byte-wide ports, or the external expansion bus. It produces the RAM chip select with a 10-bit RAM word address, an expansion select, and the read-data byte returned to the processor.

In the default map the on-board RAM fills the top 1 KB of the address space, so the processor's reset and interrupt vectors are held in writable memory. A jumper input turns on a remap mode. In that mode the RAM is cut into four 256-byte pages, which appear at address pages 0x00, 0x01, 0xFE and 0xFF. This gives the processor a zero page and a stack page while the vectors stay in RAM. The block holds one register: an 8-bit output latch at 0x7FFE that raises a one-clock strobe on every write. A byte-wide input port can be read at 0x7FFF. A write to the output address has the same effect whatever agent on the bus produced it, for example program code or a front-panel deposit. Every address that is not claimed goes to the expansion bus, which is where low-memory expansion RAM is meant to be fitted.

Top module: `memmap_decoder`

## Requirements
- R1: With `remap_en`=0 and `bus_valid`=1, any address 0xFC00..0xFFFF asserts `ram_cs` and drives `ram_addr` = address bits [9:0]. `ext_sel` stays 0.
- R2: With `remap_en`=1, address pages 0x00, 0x01, 0xFE and 0xFF select RAM pages 0, 1, 2 and 3. The result is `ram_addr` = {page index[1:0], address[7:0]}. Pages 0xFC and 0xFD are then not RAM and go to expansion.
- R3: A cycle with `bus_valid`=1, `cpu_rnw`=0 and address 0x7FFE loads `cpu_wdata` into `out_port` at the next rising clock. `out_stb` is 1 for exactly the clock cycle that follows each such write cycle.
- R4: A read (`cpu_rnw`=1) of 0x7FFF returns `in_port` on `cpu_rdata`. A read of 0x7FFE returns the current `out_port` value.
- R5: A valid cycle to any address that is neither RAM (in the active mode) nor 0x7FFE/0x7FFF asserts `ext_sel` and returns `ext_rdata` on `cpu_rdata`.
- R6: The two port addresses never assert `ram_cs` or `ext_sel`, in either mode. A write to 0x7FFF and a read of 0x7FFE leave `out_port` unchanged and raise no strobe.
- R7: While `bus_valid`=0, `ram_cs` and `ext_sel` are 0 and `cpu_rdata` is 0x00. A write presented with `bus_valid`=0 does not change `out_port`.
- R8: After reset, `out_port` is 0x00 and `out_stb` is 0.
- R9: A read of a RAM address returns `ram_rdata` on `cpu_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| bus_valid | input | 1 | Address and control are valid this cycle |
| cpu_wdata | input | 8 | Write data from the bus |
| remap_en | input | 1 | Jumper: 1 = four-page remap mode |
| in_port | input | 8 | External input port byte |
| ram_rdata | input | 8 | Data from the RAM array |
| ext_rdata | input | 8 | Data from the expansion bus |
| ram_cs | output | 1 | On-board RAM chip select |
| ram_addr | output | 10 | RAM word address |
| ext_sel | output | 1 | Expansion space select |
| out_port | output | 8 | Latched output byte |
| out_stb | output | 1 | One-clock pulse after each output write |
| cpu_rdata | output | 8 | Read data returned to the processor |

## Verification
All decode results (`ram_cs`, `ram_addr`, `ext_sel`, `cpu_rdata`) are combinational and are due in the same cycle as the address. The bench therefore changes inputs on the falling edge and samples them 1 ns later, with no clock edge in between. The output latch and its strobe are registered once: after a write cycle driven at a falling edge, the bench checks them 1 ns after the next rising edge. It checks again one cycle later, to confirm that the strobe has dropped and that the latch holds its value. The "no effect" cases for writes are checked by reading `out_port` and `out_stb` in that same post-edge slot.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_RAM  = 3'd1,
    RGN_OUTP = 3'd2,
    RGN_INP  = 3'd3,
    RGN_EXT  = 3'd4
  } region_e;
endpackage

// File: rtl/mm_addr_decode.sv
module mm_addr_decode
  import memmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RAM_AW = 10,
  parameter int PAGE_W = 8,
  parameter logic [ADDR_W-1:0] OUT_ADDR = 16'h7FFE,
  parameter logic [ADDR_W-1:0] IN_ADDR  = 16'h7FFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              valid,
  input  logic              remap,
  output region_e           region,
  output logic [RAM_AW-1:0] ram_idx
);
  localparam int HI_W   = ADDR_W - PAGE_W;
  localparam int IDX_W  = RAM_AW - PAGE_W;
  localparam int NPAGES = 1 << IDX_W;
  localparam int HALF   = NPAGES / 2;
  localparam logic [HI_W-1:0] LOW_LIM  = HI_W'(HALF);
  localparam logic [HI_W-1:0] TOP_BASE = HI_W'((1 << HI_W) - HALF);

  // Default map: RAM is the top NPAGES pages of the address space.
  function automatic logic hit_default(input logic [HI_W-1:0] pg);
    return &pg[HI_W-1:IDX_W];
  endfunction

  // Remap: lower half of the RAM pages at the bottom, upper half at the top.
  function automatic logic hit_remap(input logic [HI_W-1:0] pg);
    return (pg < LOW_LIM) || (pg >= TOP_BASE);
  endfunction

  // In both modes the RAM page index is the low bits of the address page.
  function automatic logic [RAM_AW-1:0] ram_word(input logic [ADDR_W-1:0] a);
    return {a[PAGE_W+IDX_W-1:PAGE_W], a[PAGE_W-1:0]};
  endfunction

  logic [HI_W-1:0] page;
  logic            ram_hit;

  assign page    = addr[ADDR_W-1:PAGE_W];
  assign ram_hit = remap ? hit_remap(page) : hit_default(page);
  assign ram_idx = ram_word(addr);

  always_comb begin
    if (!valid)                region = RGN_NONE;
    else if (addr == OUT_ADDR) region = RGN_OUTP;
    else if (addr == IN_ADDR)  region = RGN_INP;
    else if (ram_hit)          region = RGN_RAM;
    else                       region = RGN_EXT;
  end
endmodule

// File: rtl/mm_port_latch.sv
module mm_port_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] out_q,
  output logic              stb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      stb   <= 1'b0;
    end else begin
      stb <= wr_fire;
      if (wr_fire) out_q <= wdata;
    end
  end

  // R3: every write fire is followed by a strobe and the written byte
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (stb && out_q == $past(wdata)));

  // R3: a strobe only ever follows a write fire
  assert_stb_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> !stb);

  // R6: without a write fire the latch keeps its value
  assert_latch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(out_q));
endmodule

// File: rtl/mm_rdata_mux.sv
module mm_rdata_mux
  import memmap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  region_e           region,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] in_port,
  input  logic [DATA_W-1:0] out_q,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    case (region)
      RGN_RAM:  rdata = ram_rdata;
      RGN_INP:  rdata = in_port;
      RGN_OUTP: rdata = out_q;
      RGN_EXT:  rdata = ext_rdata;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 10,
  parameter int PAGE_W = 8,
  parameter logic [ADDR_W-1:0] OUT_ADDR = 16'h7FFE,
  parameter logic [ADDR_W-1:0] IN_ADDR  = 16'h7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rnw,
  input  logic              bus_valid,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              remap_en,
  input  logic [DATA_W-1:0] in_port,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              ram_cs,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ext_sel,
  output logic [DATA_W-1:0] out_port,
  output logic              out_stb,
  output logic [DATA_W-1:0] cpu_rdata
);
  region_e region;
  logic    port_hit;
  logic    out_wr_fire;

  mm_addr_decode #(
    .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .PAGE_W(PAGE_W),
    .OUT_ADDR(OUT_ADDR), .IN_ADDR(IN_ADDR)
  ) u_decode (
    .addr(cpu_addr), .valid(bus_valid), .remap(remap_en),
    .region(region), .ram_idx(ram_addr)
  );

  assign ram_cs      = (region == RGN_RAM);
  assign ext_sel     = (region == RGN_EXT);
  assign port_hit    = (region == RGN_OUTP) || (region == RGN_INP);
  assign out_wr_fire = (region == RGN_OUTP) && !cpu_rnw;

  mm_port_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_fire(out_wr_fire),
    .wdata(cpu_wdata), .out_q(out_port), .stb(out_stb)
  );

  mm_rdata_mux #(.DATA_W(DATA_W)) u_mux (
    .region(region), .ram_rdata(ram_rdata), .in_port(in_port),
    .out_q(out_port), .ext_rdata(ext_rdata), .rdata(cpu_rdata)
  );

  // R6: at most one target is selected per cycle
  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_cs, ext_sel, port_hit}));

  // R7: an idle bus selects nothing and returns zero
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (!ram_cs && !ext_sel && cpu_rdata == '0));

  // R1: the top 1 KB (vectors included) is RAM in the default map
  assert_top_is_ram_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !remap_en && (&cpu_addr[ADDR_W-1:RAM_AW]))
      |-> (ram_cs && ram_addr == cpu_addr[RAM_AW-1:0]));

  // R4: the input port address returns the input pins
  assert_input_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && cpu_rnw && cpu_addr == IN_ADDR) |-> (cpu_rdata == in_port));

  // R5: expansion select hands the bus data back
  assert_ext_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel |-> (cpu_rdata == ext_rdata));
endmodule

// File: tb/test_memmap_decoder.sv
module test_memmap_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rnw = 1'b1;
  logic        bus_valid = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic        remap_en = 1'b0;
  logic [7:0]  in_port = 8'h3C;
  logic [7:0]  ram_rdata = 8'h5A;
  logic [7:0]  ext_rdata = 8'hE7;
  logic        ram_cs, ext_sel, out_stb;
  logic [9:0]  ram_addr;
  logic [7:0]  out_port, cpu_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memmap_decoder i_memmap_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
    .bus_valid(bus_valid), .cpu_wdata(cpu_wdata), .remap_en(remap_en),
    .in_port(in_port), .ram_rdata(ram_rdata), .ext_rdata(ext_rdata),
    .ram_cs(ram_cs), .ram_addr(ram_addr), .ext_sel(ext_sel),
    .out_port(out_port), .out_stb(out_stb), .cpu_rdata(cpu_rdata)
  );

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  // drive at falling edge, settle 1 ns
  task automatic put(input logic [15:0] a, input logic rnw, input logic v, input logic [7:0] wd);
    @(negedge clk);
    cpu_addr = a; cpu_rnw = rnw; bus_valid = v; cpu_wdata = wd;
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    check("R8 out_port reset", 16'(out_port), 16'h00);
    check("R8 out_stb reset", 16'(out_stb), 16'h0);
  endtask

  task automatic t_default_ram();
    remap_en = 1'b0;
    put(16'hFFFC, 1, 1, 8'h00);
    check("R1 vector cs", 16'(ram_cs), 16'h1);
    check("R1 vector addr", 16'(ram_addr), 16'h3FC);
    check("R1 no ext", 16'(ext_sel), 16'h0);
    check("R9 ram read", 16'(cpu_rdata), 16'h5A);
    put(16'hFC00, 1, 1, 8'h00);
    check("R1 base addr", 16'(ram_addr), 16'h000);
    check("R1 base cs", 16'(ram_cs), 16'h1);
    put(16'hFBFF, 1, 1, 8'h00);
    check("R1 below RAM not cs", 16'(ram_cs), 16'h0);
    check("R5 below RAM ext", 16'(ext_sel), 16'h1);
    put(16'h0010, 1, 1, 8'h00);
    check("R1 low page not RAM default", 16'(ram_cs), 16'h0);
  endtask

  task automatic t_remap();
    remap_en = 1'b1;
    put(16'h0012, 1, 1, 8'h00);
    check("R2 page00 cs", 16'(ram_cs), 16'h1);
    check("R2 page00 addr", 16'(ram_addr), 16'h012);
    put(16'h01FF, 1, 1, 8'h00);
    check("R2 page01 addr", 16'(ram_addr), 16'h1FF);
    put(16'hFE34, 1, 1, 8'h00);
    check("R2 pageFE addr", 16'(ram_addr), 16'h234);
    put(16'hFFFD, 1, 1, 8'h00);
    check("R2 pageFF addr", 16'(ram_addr), 16'h3FD);
    check("R2 pageFF cs", 16'(ram_cs), 16'h1);
    put(16'hFC00, 1, 1, 8'h00);
    check("R2 pageFC not RAM", 16'(ram_cs), 16'h0);
    check("R2 pageFC ext", 16'(ext_sel), 16'h1);
    put(16'hFD80, 1, 1, 8'h00);
    check("R2 pageFD ext", 16'(ext_sel), 16'h1);
    put(16'h0200, 1, 1, 8'h00);
    check("R2 page02 ext", 16'(ext_sel), 16'h1);
    remap_en = 1'b0;
  endtask

  task automatic t_out_write();
    put(16'h7FFE, 0, 1, 8'hA5);
    check("R3 no early strobe", 16'(out_stb), 16'h0);
    after_edge();
    check("R3 latch loaded", 16'(out_port), 16'hA5);
    check("R3 strobe high", 16'(out_stb), 16'h1);
    put(16'h7FFE, 0, 1, 8'h3F);
    after_edge();
    check("R3 back-to-back data", 16'(out_port), 16'h3F);
    check("R3 back-to-back strobe", 16'(out_stb), 16'h1);
    put(16'h1234, 1, 0, 8'h00);
    after_edge();
    check("R3 strobe one clock", 16'(out_stb), 16'h0);
    check("R3 latch holds", 16'(out_port), 16'h3F);
    remap_en = 1'b1;
    put(16'h7FFE, 0, 1, 8'h81);
    check("R6 out addr no ram in remap", 16'(ram_cs), 16'h0);
    after_edge();
    check("R3 write in remap", 16'(out_port), 16'h81);
    remap_en = 1'b0;
  endtask

  task automatic t_in_read();
    in_port = 8'hC3;
    put(16'h7FFF, 1, 1, 8'h00);
    check("R4 input read", 16'(cpu_rdata), 16'hC3);
    in_port = 8'h19;
    #1;
    check("R4 input follows pins", 16'(cpu_rdata), 16'h19);
    put(16'h7FFE, 1, 1, 8'h00);
    check("R4 out readback", 16'(cpu_rdata), 16'h81);
  endtask

  task automatic t_ext();
    ext_rdata = 8'h6D;
    put(16'h4000, 1, 1, 8'h00);
    check("R5 ext sel", 16'(ext_sel), 16'h1);
    check("R5 ext data", 16'(cpu_rdata), 16'h6D);
    check("R5 no ram", 16'(ram_cs), 16'h0);
    put(16'h7FFD, 0, 1, 8'h11);
    check("R5 neighbour ext", 16'(ext_sel), 16'h1);
    after_edge();
    check("R5 neighbour no strobe", 16'(out_stb), 16'h0);
  endtask

  task automatic t_port_guard();
    put(16'h7FFF, 0, 1, 8'hEE);
    check("R6 in addr no ext", 16'(ext_sel), 16'h0);
    check("R6 in addr no ram", 16'(ram_cs), 16'h0);
    after_edge();
    check("R6 write to input ignored", 16'(out_port), 16'h81);
    check("R6 write to input no strobe", 16'(out_stb), 16'h0);
    put(16'h7FFE, 1, 1, 8'hEE);
    check("R6 out addr no ext", 16'(ext_sel), 16'h0);
    after_edge();
    check("R6 read of out no strobe", 16'(out_stb), 16'h0);
    check("R6 read of out no change", 16'(out_port), 16'h81);
  endtask

  task automatic t_idle();
    put(16'hFFFC, 1, 0, 8'h00);
    check("R7 idle no ram", 16'(ram_cs), 16'h0);
    check("R7 idle no ext", 16'(ext_sel), 16'h0);
    check("R7 idle rdata", 16'(cpu_rdata), 16'h00);
    put(16'h7FFE, 0, 0, 8'h77);
    after_edge();
    check("R7 idle write ignored", 16'(out_port), 16'h81);
    check("R7 idle no strobe", 16'(out_stb), 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_default_ram();
    t_remap();
    t_out_write();
    t_in_read();
    t_ext();
    t_port_guard();
    t_idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule